// File: doc/BRIEF.md
# Linked-Chain Search Processing Unit

This unit walks a singly linked chain of nodes held in on-chip node memory, one job at a time. A job brings an outer-iteration tag, a search key, a chain head pointer and a table-select bit. Starting at the head, the unit reads one node at a time and moves on while the pointer is non-null and the node's key differs from the search key. It stops on a key match or a null pointer. It then returns the tag, the select bit and the final pointer: the matching node address on a hit, or null on a miss.

The number of steps per job depends on the data, so the unit runs each job to completion before it takes the next one. It signals this through the valid/ready handshakes on the job and result sides. Dependences carried through the inner loop therefore need no extra logic. Null is encoded as all zeros, and node address 0 is reserved and never holds a node.

With `SHARED=1` the unit holds two independent chain tables, and the select bit of each job chooses which table is walked. The node tables are filled through a simple write port.

Top module: `chain_walk_unit`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: A job is taken only on a cycle where `in_valid` and `in_ready` are both 1. From the cycle after acceptance until the result has been handed off, `in_ready` is 0, and `in_valid` activity in that window has no effect on the running job.
- R3: The walk starts at `in_head`. While the pointer is non-zero and the key of the node at that pointer differs from `in_key`, the pointer is replaced by the node's next pointer. Address 0 means null and is never read.
- R4: On a key match `out_ptr` is the address of the matching node. When the walk reaches null, `out_ptr` is 0. A job whose head is 0 returns 0.
- R5: When n nodes are visited, `out_valid` rises 2n+1 clock cycles after the accepting edge. A null head gives a latency of 1 cycle.
- R6: While `out_valid`=1 and `out_ready`=0, the result holds with all fields stable. After the handshake edge, `out_valid` is 0 and `in_ready` is 1.
- R7: `out_tag` and `out_sel` equal the `in_tag` and `in_sel` of the job that produced the result.
- R8: `in_sel`=0 walks table 0 and `in_sel`=1 walks table 1. `wr_sel` chooses the table that a write updates. The two tables are independent.
- R9: When several nodes on a chain hold the search key, the one nearest the head is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Node write strobe |
| wr_sel | input | 1 | Table chosen by the write |
| wr_addr | input | PTR_W | Node address written |
| wr_key | input | KEY_W | Key stored in the node |
| wr_next | input | PTR_W | Next pointer stored in the node |
| in_valid | input | 1 | Job offered |
| in_ready | output | 1 | Unit can take a job |
| in_tag | input | TAG_W | Outer-iteration tag |
| in_sel | input | 1 | Table/loop select |
| in_key | input | KEY_W | Search key |
| in_head | input | PTR_W | Chain head pointer |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Result consumer ready |
| out_tag | output | TAG_W | Echoed tag |
| out_sel | output | 1 | Echoed select |
| out_ptr | output | PTR_W | Matching node address or 0 |

## Verification
A corrupted walk state shows at the ports in one of three ways: a wrong `out_ptr`, the wrong `out_valid` cycle, or a tag from another job. Because every visited node adds exactly two cycles, one skipped or repeated step shifts the result cycle by two, and the bench compares that cycle exactly. A lost job register shows up at the first result through the echoed tag and select. A stuck handshake shows up within one cycle, when `in_ready` fails to return after the result handoff.

// File: rtl/cw_pkg.sv
package cw_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_READ = 2'd1,
      ST_CMP  = 2'd2,
      ST_DONE = 2'd3
   } walk_state_t;
endpackage

// File: rtl/cw_node_mem.sv
module cw_node_mem #(
   parameter int KEY_W = 16,
   parameter int PTR_W = 6
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [PTR_W-1:0] wr_addr,
   input  logic [KEY_W-1:0] wr_key,
   input  logic [PTR_W-1:0] wr_next,
   input  logic             rd_en,
   input  logic [PTR_W-1:0] rd_addr,
   output logic [KEY_W-1:0] rd_key,
   output logic [PTR_W-1:0] rd_next
);
   localparam int DEPTH = 1 << PTR_W;

   logic [KEY_W-1:0] key_mem  [DEPTH];
   logic [PTR_W-1:0] next_mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         key_mem[wr_addr]  <= wr_key;
         next_mem[wr_addr] <= wr_next;
      end
      if (rd_en) begin
         rd_key  <= key_mem[rd_addr];
         rd_next <= next_mem[rd_addr];
      end
   end
endmodule

// File: rtl/cw_walk_fsm.sv
module cw_walk_fsm
   import cw_pkg::*;
#(
   parameter int TAG_W = 6,
   parameter int KEY_W = 16,
   parameter int PTR_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [TAG_W-1:0] in_tag,
   input  logic             in_sel,
   input  logic [KEY_W-1:0] in_key,
   input  logic [PTR_W-1:0] in_head,
   output logic             rd_en,
   output logic [PTR_W-1:0] rd_addr,
   output logic             rd_sel,
   input  logic [KEY_W-1:0] rd_key,
   input  logic [PTR_W-1:0] rd_next,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [TAG_W-1:0] out_tag,
   output logic             out_sel,
   output logic [PTR_W-1:0] out_ptr
);
   localparam logic [PTR_W-1:0] NULL_PTR = '0;

   walk_state_t      state_q;
   logic [TAG_W-1:0] tag_q;
   logic             sel_q;
   logic [KEY_W-1:0] key_q;
   logic [PTR_W-1:0] ptr_q;
   logic             key_hit;

   assign key_hit = (rd_key == key_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         tag_q   <= '0;
         sel_q   <= 1'b0;
         key_q   <= '0;
         ptr_q   <= NULL_PTR;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (in_valid) begin
                  tag_q   <= in_tag;
                  sel_q   <= in_sel;
                  key_q   <= in_key;
                  ptr_q   <= in_head;
                  state_q <= (in_head == NULL_PTR) ? ST_DONE : ST_READ;
               end
            end
            ST_READ: state_q <= ST_CMP;
            ST_CMP: begin
               if (key_hit) begin
                  state_q <= ST_DONE;
               end else begin
                  ptr_q   <= rd_next;
                  state_q <= (rd_next == NULL_PTR) ? ST_DONE : ST_READ;
               end
            end
            ST_DONE: begin
               if (out_ready) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign in_ready  = (state_q == ST_IDLE);
   assign out_valid = (state_q == ST_DONE);
   assign rd_en     = (state_q == ST_READ);
   assign rd_addr   = ptr_q;
   assign rd_sel    = sel_q;
   assign out_tag   = tag_q;
   assign out_sel   = sel_q;
   assign out_ptr   = ptr_q;

   // R2: after an accepted job the unit is busy
   a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);

   // R3: null is never dereferenced
   a_r3_no_null_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (rd_addr != NULL_PTR));

   // R4: a key match reports the address just compared
   a_r4_hit_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CMP && key_hit) |=> (out_valid && out_ptr == $past(rd_addr)));

   // R4: reaching null reports zero
   a_r4_miss_null: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CMP && !key_hit && rd_next == NULL_PTR) |=> (out_valid && out_ptr == NULL_PTR));

   // R6: a stalled result holds steady
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_ptr) && $stable(out_tag) && $stable(out_sel)));

   // R6: a handed-off result frees the unit
   a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready) |=> (!out_valid && in_ready));
endmodule

// File: rtl/chain_walk_unit.sv
module chain_walk_unit #(
   parameter int TAG_W  = 6,
   parameter int KEY_W  = 16,
   parameter int PTR_W  = 6,
   parameter bit SHARED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [PTR_W-1:0] wr_addr,
   input  logic [KEY_W-1:0] wr_key,
   input  logic [PTR_W-1:0] wr_next,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [TAG_W-1:0] in_tag,
   input  logic             in_sel,
   input  logic [KEY_W-1:0] in_key,
   input  logic [PTR_W-1:0] in_head,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [TAG_W-1:0] out_tag,
   output logic             out_sel,
   output logic [PTR_W-1:0] out_ptr
);
   generate
      if (PTR_W < 2 || PTR_W > 12) begin : g_bad_ptr
         $error("chain_walk_unit: PTR_W must lie in 2..12");
      end
      if (KEY_W < 1 || TAG_W < 1) begin : g_bad_width
         $error("chain_walk_unit: KEY_W and TAG_W must be positive");
      end
   endgenerate

   logic             rd_en;
   logic [PTR_W-1:0] rd_addr;
   logic             rd_sel;
   logic [KEY_W-1:0] rd_key;
   logic [PTR_W-1:0] rd_next;
   logic             job_sel;

   generate
      if (SHARED) begin : g_two_tables
         logic [KEY_W-1:0] key_t0, key_t1;
         logic [PTR_W-1:0] nxt_t0, nxt_t1;

         cw_node_mem #(.KEY_W(KEY_W), .PTR_W(PTR_W)) i_mem0 (
            .clk(clk), .wr_en(wr_en && !wr_sel), .wr_addr(wr_addr),
            .wr_key(wr_key), .wr_next(wr_next), .rd_en(rd_en),
            .rd_addr(rd_addr), .rd_key(key_t0), .rd_next(nxt_t0));
         cw_node_mem #(.KEY_W(KEY_W), .PTR_W(PTR_W)) i_mem1 (
            .clk(clk), .wr_en(wr_en && wr_sel), .wr_addr(wr_addr),
            .wr_key(wr_key), .wr_next(wr_next), .rd_en(rd_en),
            .rd_addr(rd_addr), .rd_key(key_t1), .rd_next(nxt_t1));

         assign rd_key  = rd_sel ? key_t1 : key_t0;
         assign rd_next = rd_sel ? nxt_t1 : nxt_t0;
         assign job_sel = in_sel;
      end else begin : g_one_table
         cw_node_mem #(.KEY_W(KEY_W), .PTR_W(PTR_W)) i_mem0 (
            .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr),
            .wr_key(wr_key), .wr_next(wr_next), .rd_en(rd_en),
            .rd_addr(rd_addr), .rd_key(rd_key), .rd_next(rd_next));
         assign job_sel = 1'b0;
      end
   endgenerate

   cw_walk_fsm #(.TAG_W(TAG_W), .KEY_W(KEY_W), .PTR_W(PTR_W)) i_fsm (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_tag(in_tag),
      .in_sel(job_sel), .in_key(in_key), .in_head(in_head),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_sel(rd_sel),
      .rd_key(rd_key), .rd_next(rd_next),
      .out_valid(out_valid), .out_ready(out_ready), .out_tag(out_tag),
      .out_sel(out_sel), .out_ptr(out_ptr));

   // R1: reset leaves the unit idle
   a_r1_reset_idle: assert property (@(posedge clk)
      $past(!rst_n) |-> (in_ready && !out_valid));
endmodule

// File: tb/test_chain_walk_unit.sv
module test_chain_walk_unit;
   localparam int TAG_W = 6;
   localparam int KEY_W = 16;
   localparam int PTR_W = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0, wr_sel = 1'b0;
   logic [PTR_W-1:0] wr_addr = '0, wr_next = '0;
   logic [KEY_W-1:0] wr_key = '0;
   logic             in_valid = 1'b0, in_sel = 1'b0;
   logic             in_ready;
   logic [TAG_W-1:0] in_tag = '0;
   logic [KEY_W-1:0] in_key = '0;
   logic [PTR_W-1:0] in_head = '0;
   logic             out_valid, out_sel;
   logic             out_ready = 1'b1;
   logic [TAG_W-1:0] out_tag;
   logic [PTR_W-1:0] out_ptr;

   int n_checks = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   chain_walk_unit #(.TAG_W(TAG_W), .KEY_W(KEY_W), .PTR_W(PTR_W), .SHARED(1'b1)) i_chain_walk_unit (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_addr(wr_addr), .wr_key(wr_key), .wr_next(wr_next),
      .in_valid(in_valid), .in_ready(in_ready), .in_tag(in_tag),
      .in_sel(in_sel), .in_key(in_key), .in_head(in_head),
      .out_valid(out_valid), .out_ready(out_ready), .out_tag(out_tag),
      .out_sel(out_sel), .out_ptr(out_ptr));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic put_node(input bit sel, input int addr, input int key, input int nxt);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel;
      wr_addr = PTR_W'(addr); wr_key = KEY_W'(key); wr_next = PTR_W'(nxt);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // Offer one job, wait for its result, check pointer, echo, latency and release.
   // busy_junk: keep in_valid high with a foreign job while the walk runs (R2).
   task automatic run_job(input string name, input int tag, input bit sel, input int key,
                          input int head, input int exp_ptr, input int exp_lat,
                          input bit busy_junk);
      int cnt;
      bit ready_low;
      @(negedge clk);
      check(in_ready == 1'b1, {name, " R2 ready before offer"}, in_ready, 1);
      in_valid = 1'b1; in_tag = TAG_W'(tag); in_sel = sel;
      in_key = KEY_W'(key); in_head = PTR_W'(head);
      @(posedge clk);
      #1;
      if (busy_junk) begin
         in_tag = TAG_W'(tag + 7); in_sel = ~sel; in_key = KEY_W'(key + 1); in_head = PTR_W'(1);
      end else begin
         in_valid = 1'b0;
      end
      cnt = 0;
      ready_low = 1'b1;
      while (cnt < 400) begin
         @(negedge clk);
         cnt++;
         if (out_valid) break;
         if (in_ready) ready_low = 1'b0;
      end
      in_valid = 1'b0;
      check(ready_low, {name, " R2 in_ready low while busy"}, ready_low, 1);
      check(out_valid == 1'b1, {name, " R5 result appears"}, out_valid, 1);
      check(cnt == exp_lat, {name, " R5 latency"}, cnt, exp_lat);
      check(out_ptr == PTR_W'(exp_ptr), {name, " R4 result pointer"}, out_ptr, exp_ptr);
      check(out_tag == TAG_W'(tag) && out_sel == sel, {name, " R7 tag/sel echo"}, out_tag, tag);
      check(in_ready == 1'b0, {name, " R2 not ready while result waits"}, in_ready, 0);
      @(negedge clk);
      check(out_valid == 1'b0 && in_ready == 1'b1, {name, " R6 release after handshake"},
            {out_valid, in_ready}, 1);
   endtask

   task automatic t_reset;
      check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
      check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
   endtask

   task automatic t_backpressure;
      int cnt;
      @(negedge clk);
      out_ready = 1'b0;
      in_valid = 1'b1; in_tag = 6'd33; in_sel = 1'b0; in_key = 16'd20; in_head = 6'd5;
      @(posedge clk);
      #1 in_valid = 1'b0;
      cnt = 0;
      while (!out_valid && cnt < 100) begin
         @(negedge clk);
         cnt++;
      end
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check(out_valid && out_ptr == 6'd9 && out_tag == 6'd33 && !in_ready,
               "R6 result held under backpressure", out_ptr, 9);
      end
      out_ready = 1'b1;
      @(negedge clk);
      check(!out_valid && in_ready, "R6 release after late ready", out_valid, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      // table 0: 5(10) -> 9(20) -> 12(30) -> null
      put_node(1'b0, 5, 10, 9);
      put_node(1'b0, 9, 20, 12);
      put_node(1'b0, 12, 30, 0);
      // table 0: duplicate keys 3(50) -> 4(50) -> null
      put_node(1'b0, 3, 50, 4);
      put_node(1'b0, 4, 50, 0);
      // table 0: long chain 20..59, key 100+addr
      for (int a = 20; a < 60; a++) put_node(1'b0, a, 100 + a, (a == 59) ? 0 : a + 1);
      // table 1: 5(30) -> 7(10) -> null
      put_node(1'b1, 5, 30, 7);
      put_node(1'b1, 7, 10, 0);

      run_job("hit first node R3",  1, 1'b0, 10, 5, 5, 3, 1'b0);
      run_job("hit third node R3",  2, 1'b0, 30, 5, 12, 7, 1'b0);
      run_job("miss R4",            3, 1'b0, 77, 5, 0, 7, 1'b0);
      run_job("null head R4",       4, 1'b1, 10, 0, 0, 1, 1'b0);
      run_job("table1 R8",          5, 1'b1, 10, 5, 7, 5, 1'b0);
      run_job("table1 key30 R8",    6, 1'b1, 30, 5, 5, 3, 1'b0);
      run_job("duplicate key R9",   7, 1'b0, 50, 3, 3, 3, 1'b0);
      run_job("long chain R5",      8, 1'b0, 159, 20, 59, 81, 1'b1);
      run_job("long miss R3",       9, 1'b0, 1, 20, 0, 81, 1'b0);
      t_backpressure();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule